// File: doc/BRIEF.md
# Half-Bridge Input Interlock Shaper

This block sits between a controller and the two gate drive stages of a half-bridge. It has a high-side command and a low-side command, both synchronous to the block clock. It turns them into two drive enables that are safe to pass on.

The block treats the two sides as equal peers. If both commands are asserted at once, both enables are turned off and stay off until the overlap ends. Each enable keeps every high level and every low level for at least a minimum number of cycles. A short command pulse, or a short gap between pulses, is stretched to that minimum rather than dropped. Steady commands pass through unchanged. The block adds no dead-time between one side turning off and the other turning on; the system has to provide it.

After reset, both enables are held off for a power-up interval. A ready flag then shows that commands are accepted. Both time constants are parameters counted in clock cycles. By default they are derived from the clock rate: 1.5 µs for the minimum width and 64 ms for the power-up interval.

Top module: `hb_interlock_shaper`

## Requirements
- R1: When the synchronized high-side and low-side commands are both 1, both drive enables are 0 on the next clock edge. This happens even if a minimum width is still running, and both stay 0 while the overlap lasts.
- R2: The lockout is symmetric. The low-side enable follows the low-side command by the same rules as the high-side enable follows the high-side command, and neither side has priority when the overlap ends.
- R3: Once an enable rises, it stays 1 for at least MIN_PULSE_CYC cycles. A shorter command pulse gives an enable pulse of exactly MIN_PULSE_CYC cycles. The only exception is a forced turn-off under R1, R7 or R9.
- R4: Once an enable falls, it stays 0 for at least MIN_PULSE_CYC cycles. A shorter low gap in the command is stretched to exactly MIN_PULSE_CYC cycles.
- R5: A command held steady for longer than MIN_PULSE_CYC cycles, including one held permanently high or low, is passed to the enable unchanged.
- R6: Each command passes a two-flop synchronizer. An allowed change of a command appears on its enable on the third rising clock edge after the command changes.
- R7: After reset is released, ready is 0 and both enables are 0 for INIT_CYC rising edges, whatever the commands are. Ready goes to 1 on edge INIT_CYC and stays 1. An enable whose command is already 1 rises on the next edge.
- R8: The two enables are never 1 together. While one enable is 1, the other may not rise. When the first one falls, the waiting one rises on the next edge, with no added dead-time.
- R9: The active-low reset is asynchronous. While it is 0, both enables and ready are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hiCmd | input | 1 | High-side on command |
| loCmd | input | 1 | Low-side on command |
| hiDrive | output | 1 | High-side gate drive enable |
| loDrive | output | 1 | Low-side gate drive enable |
| ready | output | 1 | Power-up interval complete |

## Verification
The bench builds the block with MIN_PULSE_CYC = 6 and INIT_CYC = 20 in place of the clock-derived defaults. With these values, every part of a stretch can be counted edge by edge: the stretched high pulse, the stretched low gap, and a lockout that cuts a running minimum short. The whole power-up interval, with the exact edge on which ready rises, fits into a few dozen cycles. The small minimum width also lets one short sequence hold one side off while the other side's enable finishes its minimum time.

// File: rtl/hb_pkg.sv
package hb_pkg;
  localparam int NUM_CH = 2;
  localparam int CH_HI  = 0;
  localparam int CH_LO  = 1;

  // Strobes from the control to the datapath
  typedef struct packed {
    logic              ready;    // power-up interval complete
    logic              lockout;  // both synchronized commands high
    logic [NUM_CH-1:0] req;      // synchronized commands, index CH_HI / CH_LO
  } hb_strobe_t;
endpackage

// File: rtl/hb_ctrl.sv
module hb_ctrl
  import hb_pkg::*;
#(
  parameter int INIT_CYC    = 20,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       hiCmd,
  input  logic       loCmd,
  output hb_strobe_t strobe
);
  localparam int INIT_W = $clog2(INIT_CYC + 1);
  localparam logic [INIT_W-1:0] INIT_LAST = INIT_W'(INIT_CYC);

  logic [NUM_CH-1:0] cmdRaw;
  logic [NUM_CH-1:0] reqSync;
  logic [INIT_W-1:0] initCnt;
  logic              initDone;

  assign cmdRaw[CH_HI] = hiCmd;
  assign cmdRaw[CH_LO] = loCmd;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_sync
    logic [SYNC_STAGES-1:0] stageQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) stageQ <= '0;
      else       stageQ <= {stageQ[SYNC_STAGES-2:0], cmdRaw[ch]};
    end
    assign reqSync[ch] = stageQ[SYNC_STAGES-1];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  initCnt <= '0;
    else if (initCnt != INIT_LAST) initCnt <= initCnt + INIT_W'(1);
  end

  assign initDone = (initCnt == INIT_LAST);

  always_comb begin
    strobe.ready   = initDone;
    strobe.lockout = &reqSync;
    strobe.req     = reqSync;
  end

  // R7
  ready_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.ready |=> strobe.ready);
endmodule

// File: rtl/hb_datapath.sv
module hb_datapath
  import hb_pkg::*;
#(
  parameter int MIN_PULSE_CYC = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  hb_strobe_t        strobe,
  output logic [NUM_CH-1:0] drive
);
  localparam int CNT_W = $clog2(MIN_PULSE_CYC + 1);
  localparam logic [CNT_W-1:0] HOLD_FULL = CNT_W'(MIN_PULSE_CYC);

  logic forceOff;
  assign forceOff = !strobe.ready || strobe.lockout;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    localparam int PEER = NUM_CH - 1 - ch;
    logic             outQ;
    logic [CNT_W-1:0] sinceEdge;
    logic             holdDone;
    logic             want;
    logic             peerOn;

    assign holdDone = (sinceEdge == HOLD_FULL);
    assign want     = strobe.req[ch];
    assign peerOn   = drive[PEER];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        outQ      <= 1'b0;
        sinceEdge <= HOLD_FULL;
      end else if (forceOff) begin
        if (outQ) begin
          outQ      <= 1'b0;
          sinceEdge <= CNT_W'(1);
        end else if (!holdDone) begin
          sinceEdge <= sinceEdge + CNT_W'(1);
        end
      end else if (holdDone && (want != outQ) && !(want && peerOn)) begin
        outQ      <= want;
        sinceEdge <= CNT_W'(1);
      end else if (!holdDone) begin
        sinceEdge <= sinceEdge + CNT_W'(1);
      end
    end

    assign drive[ch] = outQ;
  end

  // R8
  excl_drive_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(drive[CH_HI] && drive[CH_LO]));

  // R1
  lockout_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.lockout |=> (drive == '0));

  // R7
  init_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.ready |=> (drive == '0));
endmodule

// File: rtl/hb_interlock_shaper.sv
module hb_interlock_shaper
  import hb_pkg::*;
#(
  parameter int CLK_KHZ       = 100000,
  parameter int MIN_PULSE_CYC = (CLK_KHZ * 3) / 2000,
  parameter int INIT_CYC      = CLK_KHZ * 64
) (
  input  logic clk,
  input  logic rstN,
  input  logic hiCmd,
  input  logic loCmd,
  output logic hiDrive,
  output logic loDrive,
  output logic ready
);
  hb_strobe_t        strobe;
  logic [NUM_CH-1:0] drive;

  hb_ctrl #(
    .INIT_CYC    (INIT_CYC),
    .SYNC_STAGES (2)
  ) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .hiCmd  (hiCmd),
    .loCmd  (loCmd),
    .strobe (strobe)
  );

  hb_datapath #(
    .MIN_PULSE_CYC (MIN_PULSE_CYC)
  ) u_datapath (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .drive  (drive)
  );

  assign hiDrive = drive[CH_HI];
  assign loDrive = drive[CH_LO];
  assign ready   = strobe.ready;
endmodule

// File: tb/hb_interlock_shaper_tb.sv
module hb_interlock_shaper_tb;
  localparam int CLK_PERIOD = 10;
  localparam int MIN_CYC    = 6;
  localparam int INIT_CYC   = 20;

  typedef struct packed {
    logic [3:0] req;
    logic       hi;
    logic       lo;
    logic [4:0] hold;
    logic       expHi;
    logic       expLo;
  } vec_t;

  localparam int NV = 23;
  localparam vec_t VECS [NV] = '{
    '{4'd6, 1'b1, 1'b0, 5'd2,  1'b0, 1'b0},  // R6 not yet through
    '{4'd6, 1'b1, 1'b0, 5'd1,  1'b1, 1'b0},  // R6 third edge
    '{4'd3, 1'b0, 1'b0, 5'd2,  1'b1, 1'b0},  // R3 short pulse held
    '{4'd3, 1'b0, 1'b0, 5'd3,  1'b1, 1'b0},  // R3
    '{4'd3, 1'b0, 1'b0, 5'd1,  1'b0, 1'b0},  // R3 ends after exactly 6
    '{4'd4, 1'b1, 1'b0, 5'd3,  1'b0, 1'b0},  // R4 gap held
    '{4'd4, 1'b1, 1'b0, 5'd2,  1'b0, 1'b0},  // R4
    '{4'd4, 1'b1, 1'b0, 5'd1,  1'b1, 1'b0},  // R4 gap exactly 6
    '{4'd5, 1'b1, 1'b0, 5'd10, 1'b1, 1'b0},  // R5 steady high
    '{4'd4, 1'b0, 1'b0, 5'd1,  1'b1, 1'b0},  // R4 one-cycle dip
    '{4'd4, 1'b1, 1'b0, 5'd2,  1'b0, 1'b0},  // R4 dip seen
    '{4'd4, 1'b1, 1'b0, 5'd5,  1'b0, 1'b0},  // R4 dip stretched
    '{4'd4, 1'b1, 1'b0, 5'd1,  1'b1, 1'b0},  // R4
    '{4'd1, 1'b1, 1'b1, 5'd2,  1'b1, 1'b0},  // R1 overlap in sync
    '{4'd1, 1'b1, 1'b1, 5'd1,  1'b0, 1'b0},  // R1 cut short
    '{4'd1, 1'b1, 1'b1, 5'd8,  1'b0, 1'b0},  // R1 held off
    '{4'd2, 1'b0, 1'b1, 5'd2,  1'b0, 1'b0},  // R2
    '{4'd2, 1'b0, 1'b1, 5'd1,  1'b0, 1'b1},  // R2 low side follows
    '{4'd8, 1'b1, 1'b0, 5'd3,  1'b0, 1'b1},  // R8 high side waits
    '{4'd8, 1'b1, 1'b0, 5'd2,  1'b0, 1'b1},  // R8
    '{4'd8, 1'b1, 1'b0, 5'd1,  1'b0, 1'b0},  // R8 low side drops
    '{4'd8, 1'b1, 1'b0, 5'd1,  1'b1, 1'b0},  // R8 next edge, no dead-time
    '{4'd3, 1'b0, 1'b0, 5'd12, 1'b0, 1'b0}   // R3 released
  };

  logic clk = 1'b0;
  logic rstN;
  logic hiCmd;
  logic loCmd;
  logic hiDrive;
  logic loDrive;
  logic ready;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  hb_interlock_shaper #(
    .CLK_KHZ       (100000),
    .MIN_PULSE_CYC (MIN_CYC),
    .INIT_CYC      (INIT_CYC)
  ) u_dut (
    .clk     (clk),
    .rstN    (rstN),
    .hiCmd   (hiCmd),
    .loCmd   (loCmd),
    .hiDrive (hiDrive),
    .loDrive (loDrive),
    .ready   (ready)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  initial begin
    rstN  = 1'b0;
    hiCmd = 1'b0;
    loCmd = 1'b0;
    repeat (3) @(negedge clk);
    chk("R9 reset hiDrive", hiDrive, 1'b0);
    chk("R9 reset loDrive", loDrive, 1'b0);
    chk("R9 reset ready", ready, 1'b0);
    rstN = 1'b1;
    repeat (INIT_CYC - 1) @(negedge clk);
    chk("R7 ready before interval", ready, 1'b0);
    @(negedge clk);
    chk("R7 ready at interval", ready, 1'b1);
    repeat (10) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      hiCmd = VECS[i].hi;
      loCmd = VECS[i].lo;
      repeat (int'(VECS[i].hold)) @(negedge clk);
      chk($sformatf("R%0d vector %0d hiDrive", VECS[i].req, i), hiDrive, VECS[i].expHi);
      chk($sformatf("R%0d vector %0d loDrive", VECS[i].req, i), loDrive, VECS[i].expLo);
    end

    // R5: long command passes
    hiCmd = 1'b1;
    repeat (10) @(negedge clk);
    chk("R5 steady high passes", hiDrive, 1'b1);

    // R9: asynchronous reset while driving
    rstN = 1'b0;
    #1;
    chk("R9 async hiDrive", hiDrive, 1'b0);
    chk("R9 async ready", ready, 1'b0);
    repeat (2) @(negedge clk);

    // R7: command held high through the power-up interval
    rstN = 1'b1;
    repeat (INIT_CYC - 1) @(negedge clk);
    chk("R7 hiDrive off during init", hiDrive, 1'b0);
    chk("R7 ready low during init", ready, 1'b0);
    @(negedge clk);
    chk("R7 ready high", ready, 1'b1);
    chk("R7 hiDrive still off", hiDrive, 1'b0);
    @(negedge clk);
    chk("R7 hiDrive rises after ready", hiDrive, 1'b1);
    chk("R7 loDrive stays off", loDrive, 1'b0);

    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 5000 && !done; c++) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected done");
    end
    #1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule